// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block sits on a narrow command bus that carries register writes one byte per clock. A command starts with a start flag that is raised only with its first byte. The command then runs: address low byte, address high byte, and up to four data bytes. The block rebuilds the 16-bit address and the 32-bit data word. It checks the address against a window defined by a base value and a mask. When the address falls inside the window, the block gives its client a 2-bit register index, the data word and a write strobe that lasts one clock.

The bus has no valid signal of its own. After the start flag, every following clock carries the next byte of the command. A command is therefore closed in one of two ways: once all six byte slots have passed, or early, when the next start flag arrives. An idle bus drives zeros, so data slots that carry no real byte produce zero bytes. When a command is closed early, the data bytes it never received are filled with zero. A command that is cut off before it carries any data byte is dropped.

Top module: `bsr_cmd_decoder`

## Requirements
- R1: The byte bus and start flag pass through one register stage before decoding. For a full six-byte command whose first byte is driven before clock edge k, `wr_en` is high for the cycle after edge k+6.
- R2: Bytes are taken in this order: address low, address high, data byte 0 (bits 7:0 of `wr_data`), byte 1 (15:8), byte 2 (23:16), byte 3 (31:24).
- R3: A write is issued only if (address & 0x03FC) == (0x0338 & 0x03FC). Address bits outside the mask, including bits 15:10, do not affect the match. Addresses outside the window produce no write.
- R4: `reg_sel` carries address bits 1:0 of the command that wrote.
- R5: `wr_en` is high for exactly one cycle per accepted command.
- R6: If a start flag arrives after at least one data byte of the current command, the current command is closed at once. Its missing data bytes read as zero. The new command starts with the same byte.
- R7: If a start flag arrives before any data byte of the current command, the current command is discarded without a write.
- R8: Bytes that arrive while no command is open are ignored and cause no write.
- R9: During and after reset, `wr_en`, `reg_sel` and `wr_data` are zero, and no command is open.
- R10: `reg_sel` and `wr_data` hold their values in every cycle in which `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_byte | input | 8 | Command byte bus |
| cmd_first | input | 1 | High with the first byte of a command only |
| reg_sel | output | 2 | Register index within the window |
| wr_data | output | 32 | Assembled data word |
| wr_en | output | 1 | One-cycle write strobe |

## Verification
The bench goes after the points where a command's length is decided. One case is a start flag right after the first data byte, which must write that byte with zeros above it. A decoder that ignores early closes would lose the write, and one that zero-fills wrongly would leak stale bytes. Another case is a start flag right after the address, which must be dropped. A decoder that wrote there would issue a spurious all-zero write. Addresses differing only in bits outside the mask must still hit, so a full-width compare would miss those writes. Garbage bytes on an idle bus must be ignored, so a decoder that leaves a command open would write them. An off-by-one in the input register or byte counter shifts the strobe by a cycle, which the per-clock comparison catches.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 2;
  localparam int DATA_BYTES = 4;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int DATA_W     = DATA_BYTES * BYTE_W;
  localparam int SLOTS      = ADDR_BYTES + DATA_BYTES;
  localparam int CNT_W      = $clog2(SLOTS + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_frame_t;
endpackage

// File: rtl/cmd_inreg.sv
module cmd_inreg
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              first_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              first_o
);
  // single retiming stage ahead of the decoder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o  <= '0;
      first_o <= 1'b0;
    end else begin
      byte_o  <= byte_i;
      first_o <= first_i;
    end
  end
endmodule

// File: rtl/cmd_assembler.sv
module cmd_assembler
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              first_i,
  output logic              close_o,
  output cmd_frame_t        frame_o
);
  logic              open_q, open_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_ins;
  logic [DATA_W-1:0] data_q, data_d, data_ins;
  logic              last_slot;

  // current byte placed into its slot of the open command
  always_comb begin
    addr_ins = addr_q;
    data_ins = data_q;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cnt_q == CNT_W'(i)) addr_ins[i*BYTE_W +: BYTE_W] = byte_i;
    end
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (cnt_q == CNT_W'(ADDR_BYTES + j)) data_ins[j*BYTE_W +: BYTE_W] = byte_i;
    end
  end

  assign last_slot = (cnt_q == CNT_W'(SLOTS - 1));

  always_comb begin
    open_d  = open_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    data_d  = data_q;
    close_o = 1'b0;
    frame_o = '{addr: addr_q, data: data_q};
    if (first_i) begin
      // an open command with at least one data byte ends here
      close_o = open_q && (cnt_q > CNT_W'(ADDR_BYTES));
      open_d  = 1'b1;
      cnt_d   = CNT_W'(1);
      addr_d  = {{(ADDR_W-BYTE_W){1'b0}}, byte_i};
      data_d  = '0;
    end else if (open_q) begin
      addr_d  = addr_ins;
      data_d  = data_ins;
      frame_o = '{addr: addr_ins, data: data_ins};
      if (last_slot) begin
        close_o = 1'b1;
        open_d  = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/cmd_window.sv
module cmd_window
  import cmd_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE  = 16'h0338,
  parameter logic [ADDR_W-1:0] MASK  = 16'h03FC,
  parameter int                SEL_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam logic [ADDR_W-1:0] BASE_M = BASE & MASK;

  assign hit_o = ((addr_i & MASK) == BASE_M);
  assign sel_o = addr_i[SEL_W-1:0];
endmodule

// File: rtl/bsr_cmd_decoder.sv
module bsr_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter logic [15:0] BASE  = 16'h0338,
  parameter logic [15:0] MASK  = 16'h03FC,
  parameter int          SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_byte,
  input  logic              cmd_first,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [31:0]       wr_data,
  output logic              wr_en
);
  logic [BYTE_W-1:0] byte_q;
  logic              first_q;
  logic              close_w;
  cmd_frame_t        frame_w;
  logic              hit_w;
  logic [SEL_W-1:0]  sel_w;
  logic              we_d;
  logic [SEL_W-1:0]  sel_d;
  logic [DATA_W-1:0] data_d;

  cmd_inreg u_inreg (
    .clk(clk), .rst_n(rst_n),
    .byte_i(cmd_byte), .first_i(cmd_first),
    .byte_o(byte_q), .first_o(first_q)
  );

  cmd_assembler u_asm (
    .clk(clk), .rst_n(rst_n),
    .byte_i(byte_q), .first_i(first_q),
    .close_o(close_w), .frame_o(frame_w)
  );

  cmd_window #(.BASE(BASE), .MASK(MASK), .SEL_W(SEL_W)) u_win (
    .addr_i(frame_w.addr), .hit_o(hit_w), .sel_o(sel_w)
  );

  always_comb begin
    we_d   = close_w && hit_w;
    sel_d  = reg_sel;
    data_d = wr_data;
    if (we_d) begin
      sel_d  = sel_w;
      data_d = frame_w.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      reg_sel <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= we_d;
      reg_sel <= sel_d;
      wr_data <= data_d;
    end
  end
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] reg_sel,
  input logic [31:0]      wr_data,
  input logic             close_w,
  input logic             hit_w
);
  // R5: strobe never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R10: outputs frozen while no write is signalled
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_data) && $stable(reg_sel)));

  // R3: a write follows a closed command whose address hit the window
  a_r3_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(close_w && hit_w));

  // R9: reset holds the strobe and data low
  always @(posedge clk) begin
    if (!rst_n) a_r9_reset_quiet: assert (!wr_en && wr_data == '0);
  end
endmodule

bind bsr_cmd_decoder cmd_decoder_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .close_w(close_w), .hit_w(hit_w)
);

// File: tb/test_bsr_cmd_decoder.sv
module test_bsr_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cmd_byte;
  logic        cmd_first;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R9";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsr_cmd_decoder i_bsr_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
    .reg_sel(reg_sel), .wr_data(wr_data), .wr_en(wr_en)
  );

  // behavioural reference model
  logic [7:0]  m_byte_d;
  logic        m_first_d;
  logic [7:0]  m_q[$];
  bit          m_open;
  logic        exp_we;
  logic [1:0]  exp_sel;
  logic [31:0] exp_data;

  task automatic emit();
    logic [15:0] a;
    logic [31:0] d;
    a = {m_q[1], m_q[0]};
    d = 0;
    for (int i = 2; i < m_q.size(); i++) d[(i-2)*8 +: 8] = m_q[i];
    if ((a & 16'h03FC) == 16'h0338) begin
      exp_we = 1; exp_sel = a[1:0]; exp_data = d;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_byte_d = 0; m_first_d = 0; m_q.delete(); m_open = 0;
      exp_we = 0; exp_sel = 0; exp_data = 0;
    end else begin
      exp_we = 0;
      if (m_first_d) begin
        if (m_open && m_q.size() >= 3) emit();
        m_q.delete(); m_q.push_back(m_byte_d); m_open = 1;
      end else if (m_open) begin
        m_q.push_back(m_byte_d);
        if (m_q.size() == 6) begin emit(); m_open = 0; m_q.delete(); end
      end
      m_first_d = cmd_first; m_byte_d = cmd_byte;
    end
  end

  always @(negedge clk) begin
    if (rst_n !== 1'bx) begin
      checks++;
      if (wr_en !== exp_we || reg_sel !== exp_sel || wr_data !== exp_data) begin
        fails++;
        $display("FAIL %s: got en=%0b sel=%0d data=%08h, expected en=%0b sel=%0d data=%08h",
                 cur_req, wr_en, reg_sel, wr_data, exp_we, exp_sel, exp_data);
      end
    end
  end

  task automatic put(input logic [7:0] b, input logic f);
    @(negedge clk); cmd_byte = b; cmd_first = f;
  endtask

  task automatic send(input logic [7:0] bytes[$]);
    foreach (bytes[i]) put(bytes[i], i == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) put(8'h00, 1'b0);
  endtask

  initial begin
    rst_n = 0; cmd_byte = 0; cmd_first = 0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    checks++;
    if (wr_en !== 0 || wr_data !== 0 || reg_sel !== 0) begin
      fails++;
      $display("FAIL R9: got en=%0b data=%08h, expected 0", wr_en, wr_data);
    end
    rst_n = 1;
    idle(3);
    cur_req = "R1 R2 R5 R10";
    send('{8'h38, 8'h03, 8'h44, 8'h33, 8'h22, 8'h11}); idle(4);
    cur_req = "R4";
    send('{8'h3B, 8'h03, 8'hA1, 8'hB2, 8'hC3, 8'hD4}); idle(4);
    send('{8'h3A, 8'h03, 8'h01, 8'h02, 8'h03, 8'h04}); idle(4);
    cur_req = "R3";
    send('{8'h38, 8'h04, 8'hFF, 8'hFF, 8'hFF, 8'hFF}); idle(4);
    send('{8'h39, 8'h13, 8'h5A, 8'h6B, 8'h7C, 8'h8D}); idle(4);
    send('{8'h3C, 8'h03, 8'h12, 8'h34, 8'h56, 8'h78}); idle(4);
    cur_req = "R6";
    send('{8'h39, 8'h03, 8'hEE});
    send('{8'h3A, 8'h03, 8'h55, 8'h66});
    send('{8'h38, 8'h03, 8'h99, 8'h88, 8'h77, 8'h66}); idle(4);
    cur_req = "R7";
    send('{8'h3B, 8'h03});
    send('{8'h38});
    send('{8'h3B, 8'h03, 8'hC0, 8'hDE, 8'hAA, 8'hBB}); idle(4);
    cur_req = "R2";
    send('{8'h38, 8'h03, 8'h7E}); idle(6);
    cur_req = "R8";
    put(8'h38, 0); put(8'h03, 0); put(8'hAB, 0); put(8'hCD, 0); put(8'hEF, 0);
    put(8'h01, 0); put(8'h02, 0); idle(4);
    cur_req = "R5 R10";
    send('{8'h39, 8'h03, 8'h10, 8'h20, 8'h30, 8'h40});
    send('{8'h3A, 8'h03, 8'h50, 8'h60, 8'h70, 8'h80}); idle(6);
    cur_req = "R9";
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    rst_n = 1; idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule